// File: doc/BRIEF.md
# Chunk Hamming ECC Engine

This unit protects one fixed-size chunk of a NAND page, 256 bytes by default, with a 22-bit single-error-correcting Hamming code. Bytes stream in one per accepted beat. A start marker opens a chunk and an end marker closes it. In generate mode the engine returns the check code for the chunk, so the code can be stored in the page's spare area. In check mode the caller supplies the stored code with the final byte. The engine then forms the syndrome, which is the stored code XOR the recomputed code, and classifies it.

The code is built from two kinds of parity pair. Each byte-address bit has a pair of line-parity bits, and each of the three bit-index bits has a pair of column-parity bits. When a single data bit flips, exactly one bit of every pair changes. The high bit of each pair then spells out the byte offset and the bit index of the error. The chunk size is a parameter. The code width follows from it as twice the address width plus six, which gives 24 bits for a 512-byte chunk.

Top module: `nand_hamming_ecc`

## Requirements
- R1: Code layout. Let A be the byte address within the chunk, counted from 0 at the start-marked byte, and let B be the bit index within the byte. For each address bit k, code bit 2k is the XOR of all data bits whose A has bit k equal to 0, and code bit 2k+1 is the XOR of those whose A has bit k equal to 1. For each index bit j (0..2), code bit 16+2j uses B bit j equal to 0 and code bit 16+2j+1 uses B bit j equal to 1. In generate mode (in_check=0), res_code holds this code and res_status is 0.
- R2: res_valid is high for exactly one cycle, the cycle after the end-marked byte is accepted. All result fields then hold until the next result.
- R3: in_ready is low for exactly the one cycle after an end-marked byte is accepted, and high otherwise once reset ends. After reset, in_ready=1 and res_valid=0.
- R4: In check mode, a syndrome of zero gives res_status=0 (clean). res_code still carries the recomputed code.
- R5: When every syndrome pair differs, the result is a single data-bit error: res_status=1, res_byte holds the high bits of the line pairs and res_bit holds the high bits of the column pairs.
- R6: A syndrome with exactly one bit set means the stored code is damaged: res_status=2.
- R7: Any other nonzero syndrome, such as one caused by two flipped data bits, gives res_status=3 (uncorrectable).
- R8: A start-marked byte restarts accumulation. Bytes from an earlier chunk that was never closed have no effect on the result.
- R9: Cycles with in_valid low are ignored, whatever values in_data and the markers carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte beat valid |
| in_ready | output | 1 | Engine can take a byte |
| in_data | input | 8 | Data byte |
| in_sof | input | 1 | Beat is the first byte of a chunk |
| in_eof | input | 1 | Beat is the last byte of a chunk |
| in_check | input | 1 | Sampled with the last byte: 1 = check against stored code, 0 = generate |
| stored_code | input | 22 | Stored code, sampled with the last byte in check mode |
| res_valid | output | 1 | Result pulse |
| res_status | output | 2 | 0 clean, 1 data bit corrected, 2 code damaged, 3 uncorrectable |
| res_code | output | 22 | Recomputed code of the chunk |
| res_byte | output | 8 | Byte offset of a correctable error |
| res_bit | output | 3 | Bit index of a correctable error |

## Verification
The assertions check the handshake timing on every cycle: the one-cycle drop of in_ready and the single result pulse after each closing byte. They also check that generate mode always reports clean, that the counter restarts on a start marker, and that every syndrome classed as correctable has one set bit per pair. Whether the code bits are the right parity sets, and whether the error classes and the reported byte and bit match the flipped data, can only be shown by the bench's scenarios. Those scenarios compare against an independent bit-by-bit model and flip chosen data and code bits.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

  typedef enum logic [1:0] {
    ECC_CLEAN    = 2'd0,
    ECC_FIXED    = 2'd1,
    ECC_CODE_BAD = 2'd2,
    ECC_FATAL    = 2'd3
  } ecc_status_e;

  // Mask of bit positions within a byte whose index bit j equals hi.
  function automatic logic [7:0] col_mask(input int j, input logic hi);
    logic [7:0] m;
    for (int b = 0; b < 8; b++) begin
      m[b] = (((b >> j) & 1) == int'(hi));
    end
    return m;
  endfunction

endpackage

// File: rtl/ecc_parity_acc.sv
module ecc_parity_acc #(
  parameter int ADDR_W = 8,
  parameter int CODE_W = 2 * ADDR_W + 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              beat_valid,
  input  logic              beat_sof,
  input  logic [7:0]        beat_data,
  output logic [CODE_W-1:0] acc_next
);
  import ecc_pkg::*;

  localparam int COL_BASE = 2 * ADDR_W;

  logic [ADDR_W-1:0] cnt_q;
  logic [ADDR_W-1:0] addr;
  logic [CODE_W-1:0] acc_q;
  logic [CODE_W-1:0] contrib;
  logic              byte_par;

  assign addr     = beat_sof ? '0 : cnt_q;
  assign byte_par = ^beat_data;

  for (genvar k = 0; k < ADDR_W; k++) begin : g_line
    assign contrib[2*k]   = byte_par & ~addr[k];
    assign contrib[2*k+1] = byte_par &  addr[k];
  end

  for (genvar j = 0; j < 3; j++) begin : g_col
    localparam logic [7:0] MLO = col_mask(j, 1'b0);
    localparam logic [7:0] MHI = col_mask(j, 1'b1);
    assign contrib[COL_BASE+2*j]   = ^(beat_data & MLO);
    assign contrib[COL_BASE+2*j+1] = ^(beat_data & MHI);
  end

  always_comb begin
    acc_next = acc_q;
    if (beat_valid) begin
      acc_next = (beat_sof ? '0 : acc_q) ^ contrib;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_next;
      if (beat_valid) begin
        cnt_q <= addr + 1'b1;
      end
    end
  end

  // R8: a start-marked beat restarts the byte count
  a_r8_sof_restart: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_sof) |=> (cnt_q == ADDR_W'(1)));

  // R9: idle cycles leave the running state untouched
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!beat_valid) |=> ($stable(acc_q) && $stable(cnt_q)));

endmodule

// File: rtl/ecc_syndrome_decode.sv
module ecc_syndrome_decode #(
  parameter int ADDR_W = 8,
  parameter int CODE_W = 2 * ADDR_W + 6
) (
  input  logic [CODE_W-1:0]    syn,
  output ecc_pkg::ecc_status_e status,
  output logic [ADDR_W-1:0]    err_byte,
  output logic [2:0]           err_bit
);
  import ecc_pkg::*;

  localparam int PAIRS    = ADDR_W + 3;
  localparam int COL_BASE = 2 * ADDR_W;

  logic [PAIRS-1:0] pair_diff;
  logic             all_diff;
  logic             one_hot;

  for (genvar i = 0; i < PAIRS; i++) begin : g_pair
    assign pair_diff[i] = syn[2*i] ^ syn[2*i+1];
  end

  for (genvar k = 0; k < ADDR_W; k++) begin : g_byte
    assign err_byte[k] = syn[2*k+1];
  end

  for (genvar j = 0; j < 3; j++) begin : g_bit
    assign err_bit[j] = syn[COL_BASE+2*j+1];
  end

  assign all_diff = &pair_diff;
  assign one_hot  = (syn != '0) && ((syn & (syn - 1'b1)) == '0);

  always_comb begin
    if (syn == '0)     status = ECC_CLEAN;
    else if (all_diff) status = ECC_FIXED;
    else if (one_hot)  status = ECC_CODE_BAD;
    else               status = ECC_FATAL;
  end

  // R5: a correctable syndrome carries one set bit per pair
  always_comb begin
    if (status == ECC_FIXED) begin
      a_r5_fixed_weight: assert ($countones(syn) == PAIRS);
    end
  end

endmodule

// File: rtl/nand_hamming_ecc.sv
module nand_hamming_ecc #(
  parameter int CHUNK_BYTES = 256,
  localparam int ADDR_W = $clog2(CHUNK_BYTES),
  localparam int CODE_W = 2 * ADDR_W + 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              in_check,
  input  logic [CODE_W-1:0] stored_code,
  output logic              res_valid,
  output logic [1:0]        res_status,
  output logic [CODE_W-1:0] res_code,
  output logic [ADDR_W-1:0] res_byte,
  output logic [2:0]        res_bit
);
  import ecc_pkg::*;

  logic              ready_q;
  logic              beat;
  logic              close;
  logic [CODE_W-1:0] code_now;
  logic [CODE_W-1:0] syn;
  ecc_status_e       dec_status;
  logic [ADDR_W-1:0] dec_byte;
  logic [2:0]        dec_bit;

  assign in_ready = ready_q;
  assign beat     = in_valid & ready_q;
  assign close    = beat & in_eof;
  assign syn      = stored_code ^ code_now;

  ecc_parity_acc #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) acc_i (
    .clk        (clk),
    .rst        (rst),
    .beat_valid (beat),
    .beat_sof   (in_sof),
    .beat_data  (in_data),
    .acc_next   (code_now)
  );

  ecc_syndrome_decode #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) dec_i (
    .syn      (syn),
    .status   (dec_status),
    .err_byte (dec_byte),
    .err_bit  (dec_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q    <= 1'b1;
      res_valid  <= 1'b0;
      res_status <= '0;
      res_code   <= '0;
      res_byte   <= '0;
      res_bit    <= '0;
    end else begin
      ready_q   <= ~close;
      res_valid <= close;
      if (close) begin
        res_code <= code_now;
        if (in_check) begin
          res_status <= dec_status;
          res_byte   <= dec_byte;
          res_bit    <= dec_bit;
        end else begin
          res_status <= ECC_CLEAN;
          res_byte   <= '0;
          res_bit    <= '0;
        end
      end
    end
  end

  // R3: one-cycle gap after a closing byte
  a_r3_ready_drop: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_eof) |=> !in_ready);

  a_r3_ready_back: assert property (@(posedge clk) disable iff (rst)
    (!in_ready) |=> in_ready);

  // R2: result follows the closing byte and lasts one cycle
  a_r2_res_follows: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_eof) |=> res_valid);

  a_r2_res_pulse: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R1: generate mode never reports an error
  a_r1_gen_clean: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_eof && !in_check) |=> (res_status == 2'd0));

endmodule

// File: tb/nand_hamming_ecc_tb_top.sv
module nand_hamming_ecc_tb_top;
  localparam int CB = 256;
  localparam int AW = 8;
  localparam int CW = 22;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid, in_sof, in_eof, in_check;
  logic [7:0]    in_data;
  logic [CW-1:0] stored_code;
  logic          in_ready, res_valid;
  logic [1:0]    res_status;
  logic [CW-1:0] res_code;
  logic [AW-1:0] res_byte;
  logic [2:0]    res_bit;

  logic [7:0] mem [CB];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  nand_hamming_ecc dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .in_check(in_check),
    .stored_code(stored_code), .res_valid(res_valid), .res_status(res_status),
    .res_code(res_code), .res_byte(res_byte), .res_bit(res_bit)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] ref_code();
    logic [CW-1:0] c = '0;
    for (int a = 0; a < CB; a++) begin
      for (int b = 0; b < 8; b++) begin
        if (mem[a][b]) begin
          for (int k = 0; k < AW; k++) c[2*k + ((a >> k) & 1)] ^= 1'b1;
          for (int j = 0; j < 3; j++) c[2*AW + 2*j + ((b >> j) & 1)] ^= 1'b1;
        end
      end
    end
    return c;
  endfunction

  task automatic fill(input int seed);
    for (int i = 0; i < CB; i++) mem[i] = 8'((i * 37 + seed * 11 + (i >> 3)) ^ seed);
  endtask

  // Drive len bytes from mem; closes with eof when close_it. Gaps insert junk idle beats.
  task automatic send(input int len, input bit close_it, input bit chk_mode,
                      input logic [CW-1:0] stored, input bit gaps);
    for (int i = 0; i < len; i++) begin
      if (gaps && (i % 5 == 2)) begin
        @(negedge clk);
        in_valid = 0; in_data = 8'h5A; in_sof = 1; in_eof = 1;
        @(posedge clk);
      end
      @(negedge clk);
      in_valid = 1; in_data = mem[i]; in_sof = (i == 0);
      in_eof = close_it && (i == len - 1);
      in_check = chk_mode; stored_code = stored;
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0; in_data = 8'h00;
  endtask

  // Called at the negedge after the closing byte.
  task automatic expect_res(input string req, input logic [1:0] st,
                            input logic [CW-1:0] code, input int by, input int bi);
    chk(res_valid == 1'b1, {req, " res_valid"}, res_valid, 1);
    chk(res_status == st, {req, " status"}, res_status, st);
    chk(res_code == code, {req, " code"}, res_code, code);
    if (st == 2'd1) begin
      chk(res_byte == AW'(by), {req, " byte"}, res_byte, by);
      chk(res_bit == 3'(bi), {req, " bit"}, res_bit, bi);
    end
    @(negedge clk);
    chk(res_valid == 1'b0, "R2 pulse one cycle", res_valid, 0);
    chk(in_ready == 1'b1, "R3 ready back", in_ready, 1);
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b1, "R3 reset ready", in_ready, 1);
    chk(res_valid == 1'b0, "R3 reset res_valid", res_valid, 0);
  endtask

  task automatic t_generate(input int seed);
    logic [CW-1:0] c;
    fill(seed); c = ref_code();
    send(CB, 1, 0, '0, 0);
    chk(in_ready == 1'b0, "R3 ready low after eof", in_ready, 0);
    expect_res("R1 generate", 2'd0, c, 0, 0);
  endtask

  task automatic t_const(input logic [7:0] v);
    logic [CW-1:0] c;
    for (int i = 0; i < CB; i++) mem[i] = v;
    c = ref_code();
    send(CB, 1, 0, '0, 0);
    expect_res("R1 constant chunk", 2'd0, c, 0, 0);
  endtask

  task automatic t_clean_check();
    logic [CW-1:0] c;
    fill(5); c = ref_code();
    send(CB, 1, 1, c, 0);
    expect_res("R4 clean check", 2'd0, c, 0, 0);
  endtask

  task automatic t_single(input int by, input int bi);
    logic [CW-1:0] c, c2;
    fill(by + bi); c = ref_code();
    mem[by][bi] = ~mem[by][bi];
    c2 = ref_code();
    send(CB, 1, 1, c, 0);
    expect_res("R5 single data bit", 2'd1, c2, by, bi);
  endtask

  task automatic t_code_bit(input int pos);
    logic [CW-1:0] c;
    fill(9); c = ref_code();
    send(CB, 1, 1, c ^ (CW'(1) << pos), 0);
    expect_res("R6 stored code bit", 2'd2, c, 0, 0);
  endtask

  task automatic t_double(input int b1, input int i1, input int b2, input int i2);
    logic [CW-1:0] c, c2;
    fill(13); c = ref_code();
    mem[b1][i1] = ~mem[b1][i1];
    mem[b2][i2] = ~mem[b2][i2];
    c2 = ref_code();
    send(CB, 1, 1, c, 0);
    expect_res("R7 double error", 2'd3, c2, 0, 0);
  endtask

  task automatic t_restart();
    logic [CW-1:0] c;
    for (int i = 0; i < CB; i++) mem[i] = 8'hC3;
    send(10, 0, 0, '0, 0);
    fill(21); c = ref_code();
    send(CB, 1, 0, '0, 0);
    expect_res("R8 sof restart", 2'd0, c, 0, 0);
  endtask

  task automatic t_gaps();
    logic [CW-1:0] c;
    fill(17); c = ref_code();
    send(CB, 1, 0, '0, 1);
    expect_res("R9 idle beats ignored", 2'd0, c, 0, 0);
  endtask

  initial begin
    rst = 1; in_valid = 0; in_sof = 0; in_eof = 0; in_check = 0;
    in_data = 0; stored_code = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    t_reset();
    t_generate(1);
    t_generate(2);
    t_const(8'hFF);
    t_const(8'h00);
    t_clean_check();
    t_single(0, 0);
    t_single(255, 7);
    t_single(165, 3);
    t_code_bit(7);
    t_code_bit(21);
    t_double(3, 1, 3, 5);
    t_double(10, 4, 200, 4);
    t_restart();
    t_gaps();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule